// File: doc/BRIEF.md
# Address-Wake Serial Receiver

This block receives asynchronous serial frames on a single line and holds each received character in a data register with status flags for software. Each bit lasts a fixed number of pulses of an oversampling tick (sixteen by default). A frame is one low start bit, then the data bits least significant first, then an optional multiprocessor bit, then one stop bit. The multiprocessor bit is present only while multiprocessor mode is on. It marks a frame as an address (1) or a data frame (0).

On a shared line with many listeners, software arms a wake filter. While the filter is armed and multiprocessor mode is on, the receiver still shifts every frame in but discards each frame whose multiprocessor bit is 0. A discarded frame sets no flag, detects no error, raises no interrupt and leaves the data register untouched. The first frame whose multiprocessor bit is 1 disarms the filter in hardware. That frame is delivered normally. From then on every frame is accepted until software arms the filter again.

Top module: `mpwake_uart_rx`

## Requirements
- R1: After reset, rxData is 0, all of dataFull, frameErr, overrun, mpBitFlag and wakeArmed are 0, and both interrupt outputs are 0.
- R2: A frame begins only when rxLine is seen low on a tick while rxEn is 1. The start is confirmed only if the line is still low OVS/2 ticks later. A low pulse shorter than that, or any low level while rxEn is 0, starts no frame.
- R3: Data bits are sampled at bit centres, least significant first. A complete accepted frame with dataFull clear loads rxData and sets dataFull.
- R4: An accepted frame whose stop bit samples as 0 sets frameErr.
- R5: An accepted frame that completes while dataFull is 1 sets overrun and leaves rxData unchanged.
- R6: A fullClr pulse clears dataFull. An errClr pulse clears frameErr and overrun.
- R7: While rxEn is 0, a frame in progress is abandoned, and rxData, dataFull, frameErr and overrun keep their values.
- R8: While wakeArmed and mpMode are both 1, a frame with multiprocessor bit 0 changes neither rxData, dataFull, frameErr, overrun nor mpBitFlag.
- R9: While the filter is armed, a frame with multiprocessor bit 1 sets mpBitFlag, clears wakeArmed and is then accepted as in R3 to R5.
- R10: rxIrq is rxIntEn AND dataFull, and errIrq is errIntEn AND (frameErr OR overrun). Both are forced to 0 while wakeArmed and mpMode are both 1.
- R11: With mpMode 0 a frame carries no multiprocessor bit and the filter is ignored. Every frame is accepted, wakeArmed keeps its value and mpBitFlag is unchanged.
- R12: With mpMode 1 and the filter not armed, every frame is accepted, and mpBitFlag takes the multiprocessor bit of each frame (0 or 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| rxLine | input | 1 | Serial input, idle high |
| ovsTick | input | 1 | Oversampling tick, OVS per bit |
| rxEn | input | 1 | Receive enable |
| mpMode | input | 1 | Frames carry a multiprocessor bit |
| wakeArmSet | input | 1 | Pulse that arms the wake filter |
| rxIntEn | input | 1 | Receive interrupt enable |
| errIntEn | input | 1 | Error interrupt enable |
| fullClr | input | 1 | Pulse that clears dataFull |
| errClr | input | 1 | Pulse that clears frameErr and overrun |
| rxData | output | DATA_W | Last delivered character |
| dataFull | output | 1 | Unread character present |
| frameErr | output | 1 | Stop bit was sampled low |
| overrun | output | 1 | Frame lost because dataFull was set |
| mpBitFlag | output | 1 | Multiprocessor bit of the last accepted frame |
| wakeArmed | output | 1 | Wake filter armed |
| rxIrq | output | 1 | Receive interrupt request |
| errIrq | output | 1 | Error interrupt request |

## Verification
The bench builds the receiver with DATA_W = 7 and OVS = 8, and ticks every second clock. A whole frame therefore lasts only about 160 clocks. This lets the bench step through the full sequence of filter states: mode off, unarmed, armed with discards, the waking frame, and re-arming with mode off. It can also cover glitch rejection, overrun, abort on disable and the interrupt gating. An odd data width and a small oversampling ratio also show that nothing is tied to eight bits or to sixteen ticks.

// File: rtl/mpwake_pkg.sv
package mpwake_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_MPB,
    ST_STOP
  } rxState_e;

  // strobes from the bit timing control to the datapath
  typedef struct packed {
    logic shiftIn;    // bitVal is the next data bit
    logic mpCapture;  // bitVal is the multiprocessor bit
    logic frameEnd;   // bitVal is the stop bit, frame complete
    logic bitVal;     // line value sampled this cycle
  } rxStrobe_t;

endpackage

// File: rtl/mpwake_rx_ctrl.sv
module mpwake_rx_ctrl
  import mpwake_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      rxLine,
  input  logic      ovsTick,
  input  logic      rxEn,
  input  logic      mpMode,
  output rxStrobe_t stb
);

  localparam int TW = (OVS > 1) ? $clog2(OVS) : 1;
  localparam int BW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [TW-1:0] MID_CNT  = TW'(OVS / 2 - 1);
  localparam logic [TW-1:0] LAST_CNT = TW'(OVS - 1);
  localparam logic [BW-1:0] LAST_BIT = BW'(DATA_W - 1);

  rxState_e        state, stateNxt;
  logic [TW-1:0]   tickCnt, tickCntNxt;
  logic [BW-1:0]   bitCnt, bitCntNxt;
  logic            atMid, atEnd;

  assign atMid = (tickCnt == MID_CNT);
  assign atEnd = (tickCnt == LAST_CNT);

  always_comb begin
    stateNxt   = state;
    tickCntNxt = tickCnt;
    bitCntNxt  = bitCnt;
    stb        = '0;
    stb.bitVal = rxLine;
    if (!rxEn) begin
      stateNxt   = ST_IDLE;
      tickCntNxt = '0;
      bitCntNxt  = '0;
    end else if (ovsTick) begin
      unique case (state)
        ST_IDLE: begin
          if (!rxLine) begin
            stateNxt   = ST_START;
            tickCntNxt = '0;
          end
        end
        ST_START: begin
          if (atMid) begin
            tickCntNxt = '0;
            bitCntNxt  = '0;
            stateNxt   = rxLine ? ST_IDLE : ST_DATA;
          end else begin
            tickCntNxt = tickCnt + 1'b1;
          end
        end
        ST_DATA: begin
          if (atEnd) begin
            stb.shiftIn = 1'b1;
            tickCntNxt  = '0;
            if (bitCnt == LAST_BIT) begin
              stateNxt = mpMode ? ST_MPB : ST_STOP;
            end else begin
              bitCntNxt = bitCnt + 1'b1;
            end
          end else begin
            tickCntNxt = tickCnt + 1'b1;
          end
        end
        ST_MPB: begin
          if (atEnd) begin
            stb.mpCapture = 1'b1;
            tickCntNxt    = '0;
            stateNxt      = ST_STOP;
          end else begin
            tickCntNxt = tickCnt + 1'b1;
          end
        end
        ST_STOP: begin
          if (atEnd) begin
            stb.frameEnd = 1'b1;
            tickCntNxt   = '0;
            stateNxt     = ST_IDLE;
          end else begin
            tickCntNxt = tickCnt + 1'b1;
          end
        end
        default: stateNxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      tickCnt <= '0;
      bitCnt  <= '0;
    end else begin
      state   <= stateNxt;
      tickCnt <= tickCntNxt;
      bitCnt  <= bitCntNxt;
    end
  end

endmodule

// File: rtl/mpwake_rx_dp.sv
module mpwake_rx_dp
  import mpwake_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxStrobe_t         stb,
  input  logic              mpMode,
  input  logic              wakeArmSet,
  input  logic              rxIntEn,
  input  logic              errIntEn,
  input  logic              fullClr,
  input  logic              errClr,
  output logic [DATA_W-1:0] rxData,
  output logic              dataFull,
  output logic              frameErr,
  output logic              overrun,
  output logic              mpBitFlag,
  output logic              wakeArmed,
  output logic              rxIrq,
  output logic              errIrq
);

  logic [DATA_W-1:0] shiftReg;
  logic              mpShadow;
  logic              filterOn;
  logic              mpNow;
  logic              accept;
  logic              wakeHit;

  assign filterOn = wakeArmed & mpMode;
  assign mpNow    = mpMode & mpShadow;
  assign accept   = stb.frameEnd & (~filterOn | mpNow);
  assign wakeHit  = accept & filterOn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      mpShadow <= 1'b0;
    end else begin
      if (stb.shiftIn)   shiftReg <= {stb.bitVal, shiftReg[DATA_W-1:1]};
      if (stb.mpCapture) mpShadow <= stb.bitVal;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData    <= '0;
      dataFull  <= 1'b0;
      frameErr  <= 1'b0;
      overrun   <= 1'b0;
      mpBitFlag <= 1'b0;
    end else begin
      if (fullClr) dataFull <= 1'b0;
      if (errClr) begin
        frameErr <= 1'b0;
        overrun  <= 1'b0;
      end
      if (accept) begin
        if (mpMode) mpBitFlag <= mpNow;
        if (dataFull) begin
          overrun <= 1'b1;
        end else begin
          rxData   <= shiftReg;
          dataFull <= 1'b1;
        end
        if (!stb.bitVal) frameErr <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wakeArmed <= 1'b0;
    end else if (wakeArmSet) begin
      wakeArmed <= 1'b1;
    end else if (wakeHit) begin
      wakeArmed <= 1'b0;
    end
  end

  assign rxIrq  = rxIntEn & dataFull & ~filterOn;
  assign errIrq = errIntEn & (frameErr | overrun) & ~filterOn;

endmodule

// File: rtl/mpwake_uart_rx.sv
module mpwake_uart_rx
  import mpwake_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxLine,
  input  logic              ovsTick,
  input  logic              rxEn,
  input  logic              mpMode,
  input  logic              wakeArmSet,
  input  logic              rxIntEn,
  input  logic              errIntEn,
  input  logic              fullClr,
  input  logic              errClr,
  output logic [DATA_W-1:0] rxData,
  output logic              dataFull,
  output logic              frameErr,
  output logic              overrun,
  output logic              mpBitFlag,
  output logic              wakeArmed,
  output logic              rxIrq,
  output logic              errIrq
);

  rxStrobe_t stb;

  mpwake_rx_ctrl #(.DATA_W(DATA_W), .OVS(OVS)) u_ctrl (
    .clk(clk), .rstN(rstN), .rxLine(rxLine), .ovsTick(ovsTick),
    .rxEn(rxEn), .mpMode(mpMode), .stb(stb)
  );

  mpwake_rx_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .mpMode(mpMode),
    .wakeArmSet(wakeArmSet), .rxIntEn(rxIntEn), .errIntEn(errIntEn),
    .fullClr(fullClr), .errClr(errClr), .rxData(rxData),
    .dataFull(dataFull), .frameErr(frameErr), .overrun(overrun),
    .mpBitFlag(mpBitFlag), .wakeArmed(wakeArmed), .rxIrq(rxIrq),
    .errIrq(errIrq)
  );

endmodule

// File: rtl/mpwake_chk.sv
module mpwake_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              rxEn,
  input logic              mpMode,
  input logic              wakeArmSet,
  input logic              fullClr,
  input logic              errClr,
  input logic [DATA_W-1:0] rxData,
  input logic              dataFull,
  input logic              frameErr,
  input logic              overrun,
  input logic              mpBitFlag,
  input logic              wakeArmed,
  input logic              rxIrq,
  input logic              errIrq
);

  assert_irq_needs_full_R10: assert property (@(posedge clk) disable iff (!rstN)
    rxIrq |-> dataFull);

  assert_armed_no_irq_R10: assert property (@(posedge clk) disable iff (!rstN)
    (wakeArmed && mpMode) |-> (!rxIrq && !errIrq));

  assert_disabled_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!rxEn && !fullClr && !errClr) |=>
      ($stable(dataFull) && $stable(frameErr) && $stable(overrun) && $stable(rxData)));

  assert_overrun_keeps_data_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrun) |-> $stable(rxData));

  assert_disarm_sets_mp_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wakeArmed) |-> mpBitFlag);

  assert_armed_no_delivery_R8: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(dataFull) && $past(wakeArmed && mpMode && !wakeArmSet)) |-> $fell(wakeArmed));

endmodule

bind mpwake_uart_rx mpwake_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_mpwake_uart_rx.sv
`timescale 1ns/1ps
module sim_mpwake_uart_rx;

  localparam int DW     = 7;
  localparam int OV     = 8;
  localparam int BITCLK = OV * 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxLine = 1'b1, ovsTick = 1'b0, rxEn = 1'b0, mpMode = 1'b0;
  logic wakeArmSet = 1'b0, rxIntEn = 1'b0, errIntEn = 1'b0;
  logic fullClr = 1'b0, errClr = 1'b0;
  logic [DW-1:0] rxData;
  logic dataFull, frameErr, overrun, mpBitFlag, wakeArmed, rxIrq, errIrq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  initial begin
    forever begin
      @(negedge clk);
      ovsTick = ~ovsTick;
    end
  end

  mpwake_uart_rx #(.DATA_W(DW), .OVS(OV)) u0 (
    .clk(clk), .rstN(rstN), .rxLine(rxLine), .ovsTick(ovsTick), .rxEn(rxEn),
    .mpMode(mpMode), .wakeArmSet(wakeArmSet), .rxIntEn(rxIntEn),
    .errIntEn(errIntEn), .fullClr(fullClr), .errClr(errClr), .rxData(rxData),
    .dataFull(dataFull), .frameErr(frameErr), .overrun(overrun),
    .mpBitFlag(mpBitFlag), .wakeArmed(wakeArmed), .rxIrq(rxIrq), .errIrq(errIrq)
  );

  // mode, arm, data, mpbit, stop | full, data, fer, mpflag, armed
  typedef struct packed {
    logic          mode;
    logic          arm;
    logic [DW-1:0] d;
    logic          mpb;
    logic          stp;
    logic          eFull;
    logic [DW-1:0] eData;
    logic          eFer;
    logic          eMp;
    logic          eArm;
  } vec_t;

  localparam int NV = 9;
  localparam logic [21:0] VECS [NV] = '{
    {1'b0, 1'b0, 7'h55, 1'b0, 1'b1, 1'b1, 7'h55, 1'b0, 1'b0, 1'b0},  // R3 R11
    {1'b1, 1'b0, 7'h2A, 1'b0, 1'b1, 1'b1, 7'h2A, 1'b0, 1'b0, 1'b0},  // R12
    {1'b1, 1'b0, 7'h13, 1'b1, 1'b1, 1'b1, 7'h13, 1'b0, 1'b1, 1'b0},  // R12
    {1'b0, 1'b0, 7'h7F, 1'b0, 1'b0, 1'b1, 7'h7F, 1'b1, 1'b1, 1'b0},  // R4 R11
    {1'b1, 1'b1, 7'h11, 1'b0, 1'b0, 1'b0, 7'h7F, 1'b0, 1'b1, 1'b1},  // R8
    {1'b1, 1'b1, 7'h42, 1'b1, 1'b1, 1'b1, 7'h42, 1'b0, 1'b1, 1'b0},  // R9
    {1'b0, 1'b1, 7'h05, 1'b0, 1'b1, 1'b1, 7'h05, 1'b0, 1'b1, 1'b1},  // R11
    {1'b1, 1'b0, 7'h33, 1'b1, 1'b0, 1'b1, 7'h33, 1'b1, 1'b1, 1'b0},  // R9 R4
    {1'b1, 1'b0, 7'h00, 1'b0, 1'b1, 1'b1, 7'h00, 1'b0, 1'b0, 1'b0}   // R12
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendBit(input logic b);
    rxLine = b;
    waitClk(BITCLK);
  endtask

  task automatic sendFrame(input logic [DW-1:0] d, input logic mpb, input logic stp,
                           input logic withMp);
    sendBit(1'b0);
    for (int i = 0; i < DW; i++) sendBit(d[i]);
    if (withMp) sendBit(mpb);
    sendBit(stp);
    rxLine = 1'b1;
    waitClk(2 * BITCLK);
  endtask

  task automatic pulseClears();
    fullClr = 1'b1;
    errClr  = 1'b1;
    waitClk(1);
    fullClr = 1'b0;
    errClr  = 1'b0;
  endtask

  task automatic pulseArm();
    wakeArmSet = 1'b1;
    waitClk(1);
    wakeArmSet = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    vec_t v;
    waitClk(4);
    // R1 reset state
    check("R1 rxData", 32'(rxData), 0);
    check("R1 flags", {dataFull, frameErr, overrun, mpBitFlag, wakeArmed}, 0);
    check("R1 irqs", {rxIrq, errIrq}, 0);
    rstN = 1'b1;
    waitClk(2);

    // R2 no start while disabled
    sendFrame(7'h3C, 1'b0, 1'b1, 1'b0);
    check("R2 disabled no frame", 32'(dataFull), 0);

    rxEn = 1'b1;
    rxIntEn = 1'b1;
    errIntEn = 1'b1;
    waitClk(2);

    // R2 short glitch rejected
    rxLine = 1'b0;
    waitClk(4);
    rxLine = 1'b1;
    waitClk(3 * BITCLK * 4);
    check("R2 glitch no frame", 32'(dataFull), 0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      v = VECS[i];
      pulseClears();
      mpMode = v.mode;
      waitClk(1);
      if (v.arm) pulseArm();
      sendFrame(v.d, v.mpb, v.stp, v.mode);
      check($sformatf("R3 R8 R9 row%0d full", i), 32'(dataFull), 32'(v.eFull));
      check($sformatf("R3 R8 row%0d data", i), 32'(rxData), 32'(v.eData));
      check($sformatf("R4 R8 row%0d fer", i), 32'(frameErr), 32'(v.eFer));
      check($sformatf("R11 R12 row%0d mpflag", i), 32'(mpBitFlag), 32'(v.eMp));
      check($sformatf("R9 R11 row%0d armed", i), 32'(wakeArmed), 32'(v.eArm));
      check($sformatf("R10 row%0d rxIrq", i), 32'(rxIrq), 32'(v.eFull));
      check($sformatf("R10 row%0d errIrq", i), 32'(errIrq), 32'(v.eFer));
    end

    // R5 overrun: dataFull still 1 with data 00
    sendFrame(7'h6B, 1'b0, 1'b1, 1'b1);
    check("R5 overrun set", 32'(overrun), 1);
    check("R5 data kept", 32'(rxData), 0);
    check("R5 still full", 32'(dataFull), 1);
    check("R10 errIrq on overrun", 32'(errIrq), 1);

    // R10 enables off
    rxIntEn = 1'b0;
    errIntEn = 1'b0;
    waitClk(1);
    check("R10 rxIrq masked", 32'(rxIrq), 0);
    check("R10 errIrq masked", 32'(errIrq), 0);
    rxIntEn = 1'b1;
    errIntEn = 1'b1;

    // R10 armed filter hides pending flags
    pulseArm();
    check("R10 armed rxIrq", 32'(rxIrq), 0);
    check("R10 armed errIrq", 32'(errIrq), 0);
    check("R10 armed flags kept", {dataFull, overrun}, 2'b11);
    mpMode = 1'b0;
    waitClk(1);
    check("R10 filter ignored irq", 32'(rxIrq), 1);

    // R7 disable holds flags and ignores a frame
    rxEn = 1'b0;
    sendFrame(7'h1E, 1'b0, 1'b0, 1'b0);
    check("R7 hold flags", {dataFull, frameErr, overrun}, 3'b101);
    check("R7 hold data", 32'(rxData), 0);

    // R6 clears
    fullClr = 1'b1;
    waitClk(1);
    fullClr = 1'b0;
    check("R6 fullClr", {dataFull, overrun}, 2'b01);
    errClr = 1'b1;
    waitClk(1);
    errClr = 1'b0;
    check("R6 errClr", {dataFull, frameErr, overrun}, 3'b000);

    // R7 abort mid-frame
    rxEn = 1'b1;
    waitClk(2);
    rxLine = 1'b0;
    waitClk(3 * BITCLK);
    rxEn = 1'b0;
    waitClk(2);
    rxLine = 1'b1;
    rxEn = 1'b1;
    waitClk(12 * BITCLK);
    check("R7 aborted frame", 32'(dataFull), 0);

    // R3 reception still works after abort
    sendFrame(7'h4D, 1'b0, 1'b1, 1'b0);
    check("R3 after abort data", 32'(rxData), 32'h4D);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule